// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of external interrupt sources and routes them to several targets. A target is one privilege mode on one hardware thread, and each target gets one interrupt request line. Each source has a programmable priority and a per-source choice of edge or level detection. Each target has its own enable mask and its own priority threshold. The request line of a target is high whenever at least one source is eligible for that target.

A target services an interrupt in two steps. It first reads its claim register, which returns the identifier of the best eligible source and takes that source out of the pending set in the same cycle. Once the handler has finished, the target writes that identifier back as a completion, and the source may then be presented again. One pending state per source is shared by all targets, so a claim by one target withdraws the source from all the others.

Some target slots can be left unpopulated through a parameter mask. An unpopulated slot has its request line held low and a claim register that always reads zero. All configuration, claim and completion traffic uses one single-cycle read/write port, with read data returned combinationally in the cycle of the read strobe.

Top module: `irq_router`

## Requirements
- R1: After reset every priority, enable, threshold and mode register is zero, every request line is low, and a claim reads 0.
- R2: A source is eligible for a target when it is pending, enabled for that target, has a nonzero priority and has a priority greater than or equal to the target's threshold. The target's request line is high exactly when some source is eligible for it. A priority of 0 is never eligible.
- R3: A claim returns the eligible source with the highest priority value. Among equal priorities the lower source number wins.
- R4: A claim clears the winning source's pending bit at the clock edge that ends the read. A claim that finds nothing eligible returns 0 and changes no state. A pending bit is cleared by nothing other than a claim.
- R5: A claimed source stays in service and cannot become pending until a completion carrying its number arrives from any populated target. A completion carrying any other number leaves it in service.
- R6: A level-mode source becomes pending whenever its input is high while it is neither pending nor in service, so it re-pends after completion if the input is still high, and does not re-pend if the input is low.
- R7: An edge-mode source (mode bit 1) records one pending event per rising edge of its input. Rising edges that arrive while the source is pending or in service are dropped.
- R8: With the default population mask 4'b1011, target 2 is unpopulated. Its request line stays low, its claim reads 0 and has no side effect, and its enable and threshold writes are ignored.
- R9: Pending state is shared, so a source claimed by one target is no longer offered to any other target.
- R10: Register map: region = addr[9:8], index = addr[7:0]. Region 0 with index s (1..31) holds the source configuration: priority in data[2:0], edge mode in data[8]. Reading region 0 at index 0 returns the pending bitmap, with bit s for source s. Region 1 with index t holds target t's enable mask, bit s for source s. Region 2 with index t holds target t's threshold in data[2:0]. Region 3 with index t is target t's claim (read) and completion (write of the source number).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Interrupt source inputs, bit s is source s (numbered 1..NSRC) |
| cfg_re | input | 1 | Read strobe; a read of region 3 is a claim |
| cfg_we | input | 1 | Write strobe; a write to region 3 is a completion |
| cfg_addr | input | ADDR_W | Region in the two top bits, index below |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data, combinational, zero when cfg_re is low |
| irq_o | output | NTGT | One interrupt request line per target |

## Verification
The sources are driven with several overlapping level patterns, so that ties and differences in priority, per-target masks and thresholds (below, equal to and above a priority) each decide a different claim winner. Completions are sent from other targets, with the wrong number and with the input both still high and already low, which separates a correct in-service lock from one that is missing or too strict. Edge-mode sources receive single pulses, repeated pulses while pending, pulses while in service and a steadily held high level, which separates per-edge capture from level sensing. A behavioural model of the pending, in-service and configuration state predicts every request line on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // register window selector, taken from the two top address bits
  typedef enum logic [1:0] {
    RG_SRC = 2'd0,
    RG_EN  = 2'd1,
    RG_THR = 2'd2,
    RG_CLM = 2'd3
  } region_e;

  // data bit that selects edge detection in a source configuration word
  localparam int EDGE_BIT = 8;

endpackage

// File: rtl/irq_gateway.sv
// Per-source capture: turns a level or edge input into one pending event
// and holds the source in service between claim and completion.
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic edge_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic insv_o
);

  logic pend_q, pend_d;
  logic insv_q, insv_d;
  logic prev_q;
  logic fire;

  always_comb begin
    fire   = edge_i ? (src_i & ~prev_q) : src_i;
    pend_d = pend_q;
    insv_d = insv_q;
    if (claim_i && pend_q) begin
      pend_d = 1'b0;
      insv_d = 1'b1;
    end else if (insv_q) begin
      if (done_i) insv_d = 1'b0;
    end else if (!pend_q && fire) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      insv_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      insv_q <= insv_d;
      prev_q <= src_i;
    end
  end

  assign pend_o = pend_q;
  assign insv_o = insv_q;

endmodule

// File: rtl/irq_target_arb.sv
// Per-target selection: highest priority wins, lower number on ties.
module irq_target_arb #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic [NSRC:1]             cand_i,
  input  logic [NSRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [IDW-1:0]            id_o,
  output logic                      hit_o
);

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p = '0;
    id_o   = '0;
    hit_o  = 1'b0;
    // scan downward so that on equal priority the lower number replaces
    for (int s = NSRC; s >= 1; s--) begin
      if (cand_i[s] && (prio_i[s] != '0) && (prio_i[s] >= thr_i) &&
          (!hit_o || (prio_i[s] >= best_p))) begin
        hit_o  = 1'b1;
        best_p = prio_i[s];
        id_o   = IDW'(s);
      end
    end
  end

endmodule

// File: rtl/irq_rst_sync.sv
// Asynchronous assertion, synchronous release.
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_sync_n = stg2_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int              NSRC        = 31,
  parameter int              NTGT        = 4,
  parameter int              PRIO_W      = 3,
  parameter int              ADDR_W      = 10,
  parameter int              DATA_W      = 32,
  parameter logic [NTGT-1:0] TGT_PRESENT = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              cfg_re,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [NTGT-1:0]   irq_o
);

  localparam int IDW   = $clog2(NSRC + 1);
  localparam int SEL_W = ADDR_W - 2;

  // ---------------------------------------------------------------- reset
  logic rst_sync_n;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // -------------------------------------------------------- address decode
  region_e            rg;
  logic [SEL_W-1:0]   sel;
  logic [NSRC:1]      src_sel;
  logic [NTGT-1:0]    tgt_sel;
  logic               live_sel;

  assign rg  = region_e'(cfg_addr[ADDR_W-1 -: 2]);
  assign sel = cfg_addr[SEL_W-1:0];

  always_comb begin
    src_sel = '0;
    for (int s = 1; s <= NSRC; s++) src_sel[s] = (sel == SEL_W'(s));
    tgt_sel  = '0;
    live_sel = 1'b0;
    for (int t = 0; t < NTGT; t++) begin
      tgt_sel[t] = (sel == SEL_W'(t));
      if (tgt_sel[t] && TGT_PRESENT[t]) live_sel = 1'b1;
    end
  end

  // ------------------------------------------------ source configuration
  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [NSRC:1]             edge_q;
  logic [NSRC:1]             src_we;

  assign src_we = (cfg_we && rg == RG_SRC) ? src_sel : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prio_q <= '0;
      edge_q <= '0;
    end else begin
      for (int s = 1; s <= NSRC; s++) begin
        if (src_we[s]) begin
          prio_q[s] <= cfg_wdata[PRIO_W-1:0];
          edge_q[s] <= cfg_wdata[EDGE_BIT];
        end
      end
    end
  end

  // ------------------------------------------------------------ gateways
  logic [NSRC:1] pend_w;
  logic [NSRC:1] insv_w;
  logic [NSRC:1] claim_vec;
  logic [NSRC:1] done_vec;

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    irq_gateway u_gw (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .src_i   (src_i[s]),
      .edge_i  (edge_q[s]),
      .claim_i (claim_vec[s]),
      .done_i  (done_vec[s]),
      .pend_o  (pend_w[s]),
      .insv_o  (insv_w[s])
    );
  end

  // -------------------------------------------------------------- targets
  logic [NSRC:1]     en_q   [NTGT];
  logic [PRIO_W-1:0] thr_q  [NTGT];
  logic [IDW-1:0]    best_id[NTGT];
  logic [NTGT-1:0]   hit;
  logic [NTGT-1:0]   en_we, thr_we, clm_rd;

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      en_we[t]  = cfg_we && (rg == RG_EN)  && tgt_sel[t];
      thr_we[t] = cfg_we && (rg == RG_THR) && tgt_sel[t];
      clm_rd[t] = cfg_re && (rg == RG_CLM) && tgt_sel[t] && TGT_PRESENT[t];
    end
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    if (TGT_PRESENT[t]) begin : g_live
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          en_q[t]  <= '0;
          thr_q[t] <= '0;
        end else begin
          if (en_we[t])  en_q[t]  <= cfg_wdata[NSRC:1];
          if (thr_we[t]) thr_q[t] <= cfg_wdata[PRIO_W-1:0];
        end
      end

      irq_target_arb #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .IDW    (IDW)
      ) u_arb (
        .cand_i (pend_w & en_q[t]),
        .prio_i (prio_q),
        .thr_i  (thr_q[t]),
        .id_o   (best_id[t]),
        .hit_o  (hit[t])
      );
    end else begin : g_absent
      assign en_q[t]    = '0;
      assign thr_q[t]   = '0;
      assign best_id[t] = '0;
      assign hit[t]     = 1'b0;
    end
  end

  assign irq_o = hit;

  // ------------------------------------------------- claim and completion
  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    for (int t = 0; t < NTGT; t++) begin
      for (int s = 1; s <= NSRC; s++) begin
        if (clm_rd[t] && (best_id[t] == IDW'(s))) claim_vec[s] = 1'b1;
      end
    end
    for (int s = 1; s <= NSRC; s++) begin
      done_vec[s] = cfg_we && (rg == RG_CLM) && live_sel &&
                    (cfg_wdata == DATA_W'(s));
    end
  end

  // ------------------------------------------------------------ read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_re) begin
      unique case (rg)
        RG_SRC: begin
          if (sel == '0) begin
            cfg_rdata[NSRC:1] = pend_w;
          end else begin
            for (int s = 1; s <= NSRC; s++) begin
              if (src_sel[s]) begin
                cfg_rdata[PRIO_W-1:0] = prio_q[s];
                cfg_rdata[EDGE_BIT]   = edge_q[s];
              end
            end
          end
        end
        RG_EN: begin
          for (int t = 0; t < NTGT; t++)
            if (tgt_sel[t]) cfg_rdata[NSRC:1] = en_q[t];
        end
        RG_THR: begin
          for (int t = 0; t < NTGT; t++)
            if (tgt_sel[t]) cfg_rdata[PRIO_W-1:0] = thr_q[t];
        end
        RG_CLM: begin
          for (int t = 0; t < NTGT; t++)
            if (clm_rd[t]) cfg_rdata[IDW-1:0] = best_id[t];
        end
        default: cfg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int              NSRC        = 31,
  parameter int              NTGT        = 4,
  parameter int              ADDR_W      = 10,
  parameter int              DATA_W      = 32,
  parameter logic [NTGT-1:0] TGT_PRESENT = 4'b1011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_re,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [NSRC:1]     src_i,
  input logic [NTGT-1:0]   irq_o,
  input logic [NSRC:1]     pend_w,
  input logic [NSRC:1]     insv_w,
  input logic [NSRC:1]     edge_q
);

  localparam int IDW   = $clog2(NSRC + 1);
  localparam int SEL_W = ADDR_W - 2;

  logic [NSRC:0] pend_full;
  logic          is_claim, rd_live, rd_dead, irq_sel;

  assign pend_full = {pend_w, 1'b0};
  assign is_claim  = cfg_re && (cfg_addr[ADDR_W-1 -: 2] == 2'd3);

  always_comb begin
    rd_live = 1'b0;
    rd_dead = 1'b0;
    irq_sel = 1'b0;
    for (int t = 0; t < NTGT; t++) begin
      if (is_claim && cfg_addr[SEL_W-1:0] == SEL_W'(t)) begin
        if (TGT_PRESENT[t]) begin
          rd_live = 1'b1;
          irq_sel = irq_o[t];
        end else begin
          rd_dead = 1'b1;
        end
      end
    end
  end

  // R4
  claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && cfg_rdata != '0) |=> !pend_full[$past(cfg_rdata[IDW-1:0])]);

  // R2
  irq_claim_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_live |-> ((cfg_rdata != '0) == irq_sel));

  // R8
  absent_claim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dead |-> (cfg_rdata == '0));

  // R5
  pend_insv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w & insv_w) == '0);

  for (genvar s = 1; s <= NSRC; s++) begin : g_src_chk
    // R5
    insv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      insv_w[s] |=> !pend_w[s]);

    // R6
    level_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_q[s] && !pend_w[s] && !insv_w[s] && src_i[s]) |=> pend_w[s]);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_w[s] && !(rd_live && cfg_rdata == DATA_W'(s))) |=> pend_w[s]);
  end

endmodule

bind irq_router irq_router_chk #(
  .NSRC        (NSRC),
  .NTGT        (NTGT),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .TGT_PRESENT (TGT_PRESENT)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_re    (cfg_re),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .src_i     (src_i),
  .irq_o     (irq_o),
  .pend_w    (pend_w),
  .insv_w    (insv_w),
  .edge_q    (edge_q)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

  localparam int NSRC = 31;
  localparam int NTGT = 4;
  localparam logic [NTGT-1:0] PRESENT = 4'b1011;

  localparam int RSRC = 0, REN = 1, RTHR = 2, RCLM = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC:1]     src;
  logic              cfg_re, cfg_we;
  logic [9:0]        cfg_addr;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic [NTGT-1:0]   irq_o;

  always #5 clk = ~clk;

  irq_router i_irq_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .cfg_re    (cfg_re),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_o     (irq_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ------------------------------------------------ behavioural reference
  bit mdl_on = 0;
  int m_prio [NSRC+1];
  bit m_edge [NSRC+1];
  bit m_pend [NSRC+1];
  bit m_insv [NSRC+1];
  bit m_prev [NSRC+1];
  bit [31:0] m_en [NTGT];
  int m_thr [NTGT];

  function automatic int mdl_best(int t);
    int best = 0, bp = 0;
    if (!PRESENT[t]) return 0;
    for (int s = 1; s <= NSRC; s++)
      if (m_pend[s] && m_en[t][s] && m_prio[s] != 0 && m_prio[s] >= m_thr[t] && m_prio[s] > bp) begin
        bp = m_prio[s];
        best = s;
      end
    return best;
  endfunction

  initial begin
    for (int s = 0; s <= NSRC; s++) begin
      m_prio[s] = 0; m_edge[s] = 0; m_pend[s] = 0; m_insv[s] = 0; m_prev[s] = 0;
    end
    for (int t = 0; t < NTGT; t++) begin m_en[t] = 0; m_thr[t] = 0; end
  end

  always @(posedge clk) begin
    if (mdl_on) begin
      int rgn, idx, cid, did;
      rgn = cfg_addr[9:8];
      idx = cfg_addr[7:0];
      cid = 0;
      did = 0;
      if (cfg_re && rgn == RCLM && idx < NTGT) cid = mdl_best(idx);
      if (cfg_we && rgn == RCLM && idx < NTGT && PRESENT[idx] &&
          cfg_wdata >= 1 && cfg_wdata <= NSRC) did = cfg_wdata;
      for (int s = 1; s <= NSRC; s++) begin
        if (cid == s) begin
          m_pend[s] = 0; m_insv[s] = 1;
        end else if (m_insv[s]) begin
          if (did == s) m_insv[s] = 0;
        end else if (!m_pend[s]) begin
          if (m_edge[s] ? (src[s] && !m_prev[s]) : src[s]) m_pend[s] = 1;
        end
        m_prev[s] = src[s];
      end
      if (cfg_we && rgn == RSRC && idx >= 1 && idx <= NSRC) begin
        m_prio[idx] = cfg_wdata[2:0];
        m_edge[idx] = cfg_wdata[8];
      end
      if (cfg_we && rgn == REN && idx < NTGT && PRESENT[idx]) m_en[idx] = cfg_wdata & 32'hFFFF_FFFE;
      if (cfg_we && rgn == RTHR && idx < NTGT && PRESENT[idx]) m_thr[idx] = cfg_wdata[2:0];
    end
  end

  // R2: every request line against the model on every clock
  always @(negedge clk) begin
    if (mdl_on) begin
      logic [NTGT-1:0] exp_irq;
      for (int t = 0; t < NTGT; t++) exp_irq[t] = (mdl_best(t) != 0);
      chk(irq_o === exp_irq, "R2 request lines vs model", irq_o, exp_irq);
    end
  end

  // ------------------------------------------------------------- stimulus
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_end();
    @(posedge clk);
    #1;
    cfg_re = 0;
    cfg_we = 0;
  endtask

  task automatic wr(input int rgn, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {2'(rgn), 8'(idx)}; cfg_wdata = data;
    strobe_end();
  endtask

  task automatic rd(input int rgn, input int idx, input int exp, input string tag);
    @(negedge clk);
    cfg_re = 1; cfg_addr = {2'(rgn), 8'(idx)};
    #1;
    chk(cfg_rdata === 32'(exp), tag, cfg_rdata, exp);
    strobe_end();
  endtask

  task automatic claim(input int t, input int exp, input string tag);
    rd(RCLM, t, exp, tag);
  endtask

  task automatic set_src(input int s, input bit v);
    @(negedge clk);
    src[s] = v;
  endtask

  task automatic pulse(input int s);
    set_src(s, 1);
    set_src(s, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 0; src = '0; cfg_re = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle(4);
    chk(irq_o === 4'b0000, "R1 request lines after reset", irq_o, 0);
    mdl_on = 1;
    claim(0, 0, "R1 claim after reset");
    rd(RSRC, 3, 0, "R1 priority after reset");
    rd(RTHR, 1, 0, "R1 threshold after reset");

    wr(RSRC, 3, 2); wr(RSRC, 5, 5); wr(RSRC, 7, 5); wr(RSRC, 9, 1);
    wr(REN, 0, (1 << 3) | (1 << 5) | (1 << 7));
    wr(REN, 1, (1 << 3) | (1 << 9));
    wr(REN, 3, (1 << 5));
    wr(RTHR, 1, 2);
    rd(RSRC, 5, 5, "R10 priority readback");
    rd(RTHR, 1, 2, "R10 threshold readback");
    rd(REN, 1, (1 << 3) | (1 << 9), "R10 enable readback");

    @(negedge clk);
    src[3] = 1; src[5] = 1; src[7] = 1; src[9] = 1;
    idle(2);
    rd(RSRC, 0, (1 << 3) | (1 << 5) | (1 << 7) | (1 << 9), "R10 pending bitmap");
    chk(irq_o === 4'b1011, "R2 lines with mixed masks", irq_o, 4'b1011);

    claim(0, 5, "R3 tie goes to lower number");
    claim(3, 0, "R9 claimed source withdrawn from other target");
    claim(0, 7, "R3 next highest");
    claim(0, 3, "R3 lowest priority last");
    claim(0, 0, "R4 empty claim");
    claim(1, 0, "R2 priority below threshold");
    wr(RTHR, 1, 1);
    claim(1, 9, "R2 priority equal to threshold");

    wr(RCLM, 1, 5);
    idle(2);
    claim(0, 5, "R6 level re-pends, R5 completion from other target");
    wr(RCLM, 0, 11);
    idle(2);
    claim(0, 0, "R5 wrong completion number");
    set_src(7, 0);
    wr(RCLM, 0, 7);
    idle(2);
    claim(0, 0, "R6 low input does not re-pend");

    wr(REN, 2, 32'hFFFF_FFFE);
    wr(RCLM, 0, 3);
    idle(2);
    chk(irq_o[2] === 1'b0, "R8 absent line low", irq_o[2], 0);
    claim(2, 0, "R8 absent claim reads zero");
    rd(REN, 2, 0, "R8 absent enable write ignored");
    claim(0, 3, "R8 absent claim had no side effect");

    wr(RSRC, 9, 0);
    wr(RCLM, 1, 9);
    idle(2);
    rd(RSRC, 0, (1 << 9), "R2 zero priority source still pending");
    claim(1, 0, "R2 zero priority never eligible");

    wr(RSRC, 12, 4 | (1 << 8));
    rd(RSRC, 12, 4 | (1 << 8), "R10 edge mode bit");
    wr(REN, 0, (1 << 3) | (1 << 5) | (1 << 7) | (1 << 12));
    pulse(12);
    pulse(12);
    idle(1);
    claim(0, 12, "R7 edge captured");
    claim(0, 0, "R7 second edge while pending dropped");
    pulse(12);
    wr(RCLM, 0, 12);
    idle(2);
    claim(0, 0, "R7 edge during service dropped");
    pulse(12);
    idle(1);
    claim(0, 12, "R7 fresh edge after completion");
    set_src(12, 1);
    idle(1);
    wr(RCLM, 0, 12);
    idle(3);
    claim(0, 0, "R7 steady high not re-pending");

    idle(2);
    report();
  end

endmodule